// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block collects level-sensitive interrupt sources, arranged in groups of eight, and turns them into two processor requests: a low-priority request and a high-priority request. Software shapes the arbitration through a small register set. Each source has an enable bit. Each group has a priority register with eight ordered slots, and each slot names one source of that group by its 3-bit in-group code. A routing register can steer the first two slots of every group to the high output. A control register can promote one source above every slot and choose which output it drives.

A source's number is `group * 8 + code`. Number 0 is reserved. For each output, a read-only vector register returns the number of the current winner in its upper six bits, or zero when nothing is pending on that output. The vectors and both requests follow the inputs combinationally. Register writes take effect at the clock edge that captures them.

Top module: `grp_vec_intc`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero. Both requests are low and both vectors read zero.
- R2: A source counts as live only while its input is high and its enable bit is set. The enable bit for source s is bit s%32 of the mask word at word index 2 + s/32 (byte offsets 0x08 and 0x0C with six groups).
- R3: A mask write is captured at the clock edge where reg_we is high. Before that edge the requests still show the old mask. From that edge on they show the new mask.
- R4: The priority register of group g sits at word index 2 + NUM_MASK + g (0x10 + 4g by default). Slot k (1..8) is the 3-bit field whose lsb is at bit 32-3k for k≤3 and at bit 24-3k for k≥4. A slot stands for source g*8 + field value. A source named in no slot never raises a request through the slots.
- R5: Among slot candidates on one output, the lower slot number wins. Within the same slot number, the lower group index wins.
- R6: The low vector is at word index 2+NUM_MASK+NUM_GROUPS (0x28) and the high vector is at the next word (0x2C). Each returns the winner in bits 31:26, with all other bits zero, and returns 0 when its output has no candidate.
- R7: The routing register (0x04) holds a 2-bit field per group g for slot 2 at bits 4g+1:4g and for slot 1 at bits 4g+3:4g+2. Value 1 sends that slot to the high output and any other value sends it to the low output. Slots 3 to 8 always go to the low output.
- R8: Control register (0x00) bits 5:0 name a promoted source and bit 8 selects its output (1 = high). When that source is live, it wins its output and raises that output even if it appears in no slot.
- R9: Source 0 never raises a request. A promoted field of 0 means that no source is promoted.
- R10: Each request is the OR of its output's live candidates and changes in the same cycle as the inputs, with no clock edge needed.
- R11: A read of the control, routing, mask or priority registers returns the last value written. Writes to the vector registers are ignored. Accesses with reg_addr[1:0] ≠ 0 or to an unmapped word are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| src_level | input | NUM_GROUPS*8 | Level-sensitive source inputs, bit s is source s |
| irq_low | output | 1 | Low-priority request |
| irq_high | output | 1 | High-priority request |

## Verification
The bench builds the block with its default six groups, which gives 48 source numbers and two mask words. This size lets every source be placed in every one of the eight slots in turn, so each slot field position and each mask bit is checked individually. Directed cases cover slot-versus-slot and group-versus-group ordering, routing values other than 1, the promoted source on both outputs, and the reserved source 0. Several thousand random register and input settings are then compared against an arithmetic model of the slot scan.

// File: rtl/gvi_pkg.sv
// Package: constants shared by the grouped-priority interrupt controller.
// Assumes 3-bit in-group codes (eight sources per group) and 6-bit source ids.
package gvi_pkg;
    localparam int REG_W      = 32;
    localparam int CODE_W     = 3;
    localparam int SLOTS      = 8;
    localparam int ID_W       = 6;
    localparam int ID_SPACE   = 1 << ID_W;
    localparam int VEC_LSB    = REG_W - ID_W;
    localparam int ROUTE_W    = 2;
    localparam int ROUTE_NIB  = 2 * ROUTE_W;
    localparam logic [ROUTE_W-1:0] ROUTE_HIGH = 2'd1;
    localparam int FORCE_HI_BIT = 8;

    // Word indices of the fixed registers; the rest follow the mask words.
    localparam int IDX_CTRL  = 0;
    localparam int IDX_ROUTE = 1;
    localparam int IDX_MASK0 = 2;

    // Lsb position of slot k (1..8) inside a group priority word.
    function automatic int slot_lsb(input int slot);
        return (slot <= 3) ? (32 - 3 * slot) : (24 - 3 * slot);
    endfunction
endpackage

// File: rtl/gvi_regfile.sv
// Module: gvi_regfile
// Holds the control, routing, mask and group priority registers.
// Assumes word-indexed writes already qualified for alignment by the parent.
module gvi_regfile
    import gvi_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int NUM_MASK   = 2,
    parameter int WIDX_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WIDX_W-1:0]           wr_idx,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            ctrl_q,
    output logic [REG_W-1:0]            route_q,
    output logic [NUM_MASK*REG_W-1:0]   mask_q,
    output logic [NUM_GROUPS*REG_W-1:0] prio_q
);
    localparam int PRIO_BASE = IDX_MASK0 + NUM_MASK;

    // Control register: promoted source and its output select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_idx == WIDX_W'(IDX_CTRL))
            ctrl_q <= wr_data;
    end

    // Routing register: slot 1/2 output steering per group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= '0;
        else if (wr_en && wr_idx == WIDX_W'(IDX_ROUTE))
            route_q <= wr_data;
    end

    for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
        // Mask word m: enable bits of sources 32m .. 32m+31.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[m*REG_W +: REG_W] <= '0;
            else if (wr_en && wr_idx == WIDX_W'(IDX_MASK0 + m))
                mask_q[m*REG_W +: REG_W] <= wr_data;
        end

        // R3: a captured mask write is visible on the following cycle.
        p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == WIDX_W'(IDX_MASK0 + m))
            |=> (mask_q[m*REG_W +: REG_W] == $past(wr_data)));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_prio
        // Priority word of group g: eight 3-bit slots.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[g*REG_W +: REG_W] <= '0;
            else if (wr_en && wr_idx == WIDX_W'(PRIO_BASE + g))
                prio_q[g*REG_W +: REG_W] <= wr_data;
        end
    end

    // R1: leaving reset, every register holds zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n))
        |-> (ctrl_q == '0 && route_q == '0 && mask_q == '0 && prio_q == '0));
endmodule

// File: rtl/gvi_slot_decode.sv
// Module: gvi_slot_decode
// Expands one group priority word into eight slot candidates: the source
// id each slot names, whether it is live and whether it is steered high.
// Assumes grp_live already has source 0 cleared.
module gvi_slot_decode
    import gvi_pkg::*;
#(
    parameter int GRP = 0
) (
    input  logic [REG_W-1:0]      prio_word,
    input  logic [ROUTE_NIB-1:0]  route_nib,
    input  logic [SLOTS-1:0]      grp_live,
    output logic [SLOTS-1:0]      slot_act,
    output logic [SLOTS-1:0]      slot_hi,
    output logic [SLOTS*ID_W-1:0] slot_id
);
    localparam logic [ID_W-CODE_W-1:0] GID = (ID_W-CODE_W)'(GRP);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int LSB = slot_lsb(k + 1);
        logic [CODE_W-1:0] code;

        // Field extraction and liveness of the source this slot names.
        assign code                  = prio_word[LSB +: CODE_W];
        assign slot_id[k*ID_W +: ID_W] = {GID, code};
        assign slot_act[k]           = grp_live[code];

        if (k == 0) begin : g_route1
            // Slot 1 steering field sits above the slot 2 field.
            assign slot_hi[k] = (route_nib[ROUTE_NIB-1 -: ROUTE_W] == ROUTE_HIGH);
        end else if (k == 1) begin : g_route2
            // Slot 2 steering field at the base of the nibble.
            assign slot_hi[k] = (route_nib[ROUTE_W-1:0] == ROUTE_HIGH);
        end else begin : g_route_fixed
            // Slots 3..8 can only reach the low output.
            assign slot_hi[k] = 1'b0;
        end
    end
endmodule

// File: rtl/gvi_arbiter.sv
// Module: gvi_arbiter
// Picks the winner for one output from candidates already ordered by
// priority (index 0 highest), with the promoted source ahead of all.
// Assumes candidate ids of live candidates are never zero.
module gvi_arbiter
    import gvi_pkg::*;
#(
    parameter int N         = 48,
    parameter bit HIGH_SIDE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      cand_act,
    input  logic [N-1:0]      cand_hi,
    input  logic [N*ID_W-1:0] cand_id,
    input  logic              forced_act,
    input  logic              forced_hi,
    input  logic [ID_W-1:0]   forced_id,
    output logic              req,
    output logic [ID_W-1:0]   win_id
);
    logic [N-1:0] elig;
    logic         forced_elig;

    // Candidates that are live and steered to this output.
    always_comb begin
        elig        = cand_act & (HIGH_SIDE ? cand_hi : ~cand_hi);
        forced_elig = forced_act && (forced_hi == HIGH_SIDE);
    end

    // Priority scan: lowest index wins, the promoted source overrides.
    always_comb begin
        win_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i])
                win_id = cand_id[i*ID_W +: ID_W];
        end
        if (forced_elig)
            win_id = forced_id;
    end

    // Request is the OR of everything eligible on this output.
    always_comb req = (|elig) || forced_elig;

    // R6: a raised request always carries a non-zero vector.
    p_req_has_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (win_id != '0));

    // R6: an idle output reports vector zero.
    p_idle_vec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (win_id == '0));

    // R8: a live promoted source owns its output.
    p_forced_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        forced_elig |-> (req && win_id == forced_id));
endmodule

// File: rtl/grp_vec_intc.sv
// Module: grp_vec_intc
// Grouped-priority vectored interrupt controller top. Combines source
// levels with enable masks, decodes every group's slots, orders the slots
// slot-major (slot number first, group index second) and arbitrates the
// low and high outputs. Assumes NUM_GROUPS <= 8 so ids fit in six bits.
module grp_vec_intc
    import gvi_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic [NUM_GROUPS*8-1:0] src_level,
    output logic                    irq_low,
    output logic                    irq_high
);
    localparam int NUM_SRC     = NUM_GROUPS * SLOTS;
    localparam int NUM_MASK    = (NUM_SRC + REG_W - 1) / REG_W;
    localparam int NUM_CAND    = NUM_GROUPS * SLOTS;
    localparam int WIDX_W      = ADDR_W - 2;
    localparam int IDX_PRIO0   = IDX_MASK0 + NUM_MASK;
    localparam int IDX_LOWVEC  = IDX_PRIO0 + NUM_GROUPS;
    localparam int IDX_HIGHVEC = IDX_LOWVEC + 1;

    logic [WIDX_W-1:0]           widx;
    logic                        aligned;
    logic [REG_W-1:0]            ctrl_q, route_q;
    logic [NUM_MASK*REG_W-1:0]   mask_q;
    logic [NUM_GROUPS*REG_W-1:0] prio_q;
    logic [ID_SPACE-1:0]         live_pad, src_pad, mask_pad;
    logic [NUM_CAND-1:0]         cand_act, cand_hi;
    logic [NUM_CAND*ID_W-1:0]    cand_id;
    logic [ID_W-1:0]             forced_id, low_id, high_id;
    logic                        forced_act;

    // Access decode: word index and alignment qualifier.
    always_comb begin
        widx    = reg_addr[ADDR_W-1:2];
        aligned = (reg_addr[1:0] == 2'b00);
    end

    gvi_regfile #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_MASK   (NUM_MASK),
        .WIDX_W     (WIDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && aligned),
        .wr_idx  (widx),
        .wr_data (reg_wdata),
        .ctrl_q  (ctrl_q),
        .route_q (route_q),
        .mask_q  (mask_q),
        .prio_q  (prio_q)
    );

    // Live sources padded to the full id space; source 0 never counts.
    always_comb begin
        src_pad  = ID_SPACE'(src_level);
        mask_pad = ID_SPACE'(mask_q);
        live_pad = src_pad & mask_pad;
        live_pad[0] = 1'b0;
    end

    // Promoted source: field value 0 means none.
    always_comb begin
        forced_id  = ctrl_q[ID_W-1:0];
        forced_act = (forced_id != '0) && live_pad[forced_id];
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [SLOTS-1:0]      s_act, s_hi;
        logic [SLOTS*ID_W-1:0] s_id;

        gvi_slot_decode #(.GRP(g)) u_dec (
            .prio_word (prio_q[g*REG_W +: REG_W]),
            .route_nib (route_q[g*ROUTE_NIB +: ROUTE_NIB]),
            .grp_live  (live_pad[g*SLOTS +: SLOTS]),
            .slot_act  (s_act),
            .slot_hi   (s_hi),
            .slot_id   (s_id)
        );

        for (genvar k = 0; k < SLOTS; k++) begin : g_place
            // Slot-major placement: index = slot * groups + group.
            assign cand_act[k*NUM_GROUPS + g]               = s_act[k];
            assign cand_hi[k*NUM_GROUPS + g]                = s_hi[k];
            assign cand_id[(k*NUM_GROUPS + g)*ID_W +: ID_W] = s_id[k*ID_W +: ID_W];
        end
    end

    gvi_arbiter #(.N(NUM_CAND), .HIGH_SIDE(1'b0)) u_arb_low (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_act   (cand_act),
        .cand_hi    (cand_hi),
        .cand_id    (cand_id),
        .forced_act (forced_act),
        .forced_hi  (ctrl_q[FORCE_HI_BIT]),
        .forced_id  (forced_id),
        .req        (irq_low),
        .win_id     (low_id)
    );

    gvi_arbiter #(.N(NUM_CAND), .HIGH_SIDE(1'b1)) u_arb_high (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_act   (cand_act),
        .cand_hi    (cand_hi),
        .cand_id    (cand_id),
        .forced_act (forced_act),
        .forced_hi  (ctrl_q[FORCE_HI_BIT]),
        .forced_id  (forced_id),
        .req        (irq_high),
        .win_id     (high_id)
    );

    // Read mux: stored registers, computed vectors, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (widx == WIDX_W'(IDX_CTRL))
                reg_rdata = ctrl_q;
            if (widx == WIDX_W'(IDX_ROUTE))
                reg_rdata = route_q;
            for (int m = 0; m < NUM_MASK; m++)
                if (widx == WIDX_W'(IDX_MASK0 + m))
                    reg_rdata = mask_q[m*REG_W +: REG_W];
            for (int g = 0; g < NUM_GROUPS; g++)
                if (widx == WIDX_W'(IDX_PRIO0 + g))
                    reg_rdata = prio_q[g*REG_W +: REG_W];
            if (widx == WIDX_W'(IDX_LOWVEC))
                reg_rdata = {low_id, {VEC_LSB{1'b0}}};
            if (widx == WIDX_W'(IDX_HIGHVEC))
                reg_rdata = {high_id, {VEC_LSB{1'b0}}};
        end
    end

    // R2: the low winner is a high, enabled source.
    p_low_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_low |-> (src_pad[low_id] && mask_pad[low_id]));

    // R2: the high winner is a high, enabled source.
    p_high_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_high |-> (src_pad[high_id] && mask_pad[high_id]));

    // R2: with every enable clear both outputs stay quiet.
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_low && !irq_high));
endmodule

// File: tb/grp_vec_intc_bench.sv
// Bench for grp_vec_intc with six groups: reset, readback, a sweep of
// every source through every slot, directed ordering cases and random
// settings compared against an arithmetic model of the slot scan.
module grp_vec_intc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;
    localparam int NS = NG * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NS-1:0] src = '0;
    logic        irq_low, irq_high;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [31:0] sh [0:11];

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_vec_intc #(.NUM_GROUPS(NG), .ADDR_W(8)) u_grp_vec_intc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_level (src),
        .irq_low   (irq_low),
        .irq_high  (irq_high)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_raw(8'(idx * 4), d);
        if (idx < 10) sh[idx] = d;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        reg_addr = 8'(idx * 4);
        #1 d = reg_rdata;
    endtask

    function automatic int lsb_of(input int k);
        return (k <= 3) ? (32 - 3 * k) : (24 - 3 * k);
    endfunction

    // Model of the arbitration for one output, from the requirements.
    function automatic logic [5:0] model_vec(input bit hi);
        logic [63:0] live;
        logic [5:0]  f, id;
        logic [1:0]  r;
        logic [2:0]  code;
        live = {sh[3], sh[2]} & {16'h0, src};
        live[0] = 1'b0;
        f = sh[0][5:0];
        if (f != 0 && live[f] && (sh[0][8] == hi)) return f;
        for (int k = 1; k <= 8; k++)
            for (int g = 0; g < NG; g++) begin
                code = sh[4+g][lsb_of(k) +: 3];
                id = 6'(g * 8 + int'(code));
                r = (k == 1) ? sh[1][4*g+2 +: 2] : (k == 2) ? sh[1][4*g +: 2] : 2'd0;
                if (live[id] && ((r == 2'd1) == hi)) return id;
            end
        return 6'd0;
    endfunction

    task automatic check_model(input string tag);
        logic [31:0] d;
        logic [5:0] el, eh;
        #1;
        el = model_vec(1'b0);
        eh = model_vec(1'b1);
        chk({tag, " irq_low"}, 32'(irq_low), 32'(el != 0));
        chk({tag, " irq_high"}, 32'(irq_high), 32'(eh != 0));
        rd(10, d); chk({tag, " low vector"}, d, {el, 26'b0});
        rd(11, d); chk({tag, " high vector"}, d, {eh, 26'b0});
    endtask

    task automatic check_vec(input string tag, input logic [5:0] el, input logic [5:0] eh);
        logic [31:0] d;
        #1;
        chk({tag, " irq_low"}, 32'(irq_low), 32'(el != 0));
        chk({tag, " irq_high"}, 32'(irq_high), 32'(eh != 0));
        rd(10, d); chk({tag, " low vector"}, d, {el, 26'b0});
        rd(11, d); chk({tag, " high vector"}, d, {eh, 26'b0});
    endtask

    task automatic clear_all();
        for (int i = 0; i < 10; i++) wr(i, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (R1..R11 run) actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 12; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, with every source input high.
        src = '1;
        for (int i = 0; i < 12; i++) begin
            rd(i, d); chk("R1 register after reset", d, 32'h0);
        end
        chk("R1 irq_low after reset", 32'(irq_low), 32'h0);
        chk("R1 irq_high after reset", 32'(irq_high), 32'h0);
        src = '0;

        // R11: readback, ignored vector writes, misaligned and unmapped words.
        for (int i = 0; i < 10; i++) begin
            wr(i, 32'hA5C3_0000 ^ (32'(i) * 32'h0101_1357));
            rd(i, d); chk("R11 readback", d, sh[i]);
        end
        wr(10, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF);
        check_model("R11 vector write ignored");
        wr_raw(8'h05, 32'h1234_5678);
        rd(1, d); chk("R11 misaligned write ignored", d, sh[1]);
        reg_addr = 8'h09; #1 chk("R11 misaligned read zero", reg_rdata, 32'h0);
        rd(12, d); chk("R11 unmapped read zero", d, 32'h0);
        clear_all();

        // R2/R4/R3 sweep: every source in every slot, then masked, then in no slot.
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        for (int g = 0; g < NG; g++)
            for (int c = 0; c < 8; c++) begin
                if (g == 0 && c == 0) continue;
                for (int k = 1; k <= 8; k++) begin
                    int id;
                    id = g * 8 + c;
                    src = NS'(1) << id;
                    wr(4 + g, 32'(c) << lsb_of(k));
                    check_vec("R4 slot field position", 6'(id), 6'd0);
                    wr(2 + id / 32, sh[2 + id / 32] & ~(32'h1 << (id % 32)));
                    check_vec("R2 mask bit clears source", 6'd0, 6'd0);
                    wr(2 + id / 32, 32'hFFFF_FFFF);
                end
                if (c != 0) begin
                    wr(4 + g, 32'h0);
                    check_vec("R4 source in no slot", 6'd0, 6'd0);
                end
                wr(4 + g, 32'h0);
            end

        // R3: mask write timing around the capturing edge.
        src = NS'(1) << 13;
        wr(4 + 1, 32'(5) << lsb_of(4));
        check_vec("R3 before mask write", 6'd13, 6'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0;
        #1 chk("R3 request held before edge", 32'(irq_low), 32'h1);
        @(negedge clk);
        reg_we = 1'b0; sh[2] = 32'h0;
        #1 chk("R3 request gone after edge", 32'(irq_low), 32'h0);
        clear_all();

        // R5: slot beats group, then group order within one slot.
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        wr(4 + 0, 32'(1) << lsb_of(2));
        wr(4 + 3, 32'(2) << lsb_of(1));
        src = '0; src[1] = 1'b1; src[26] = 1'b1;
        check_vec("R5 lower slot wins", 6'd26, 6'd0);
        wr(4 + 2, 32'(4) << lsb_of(1));
        src[20] = 1'b1;
        check_vec("R5 lower group wins same slot", 6'd20, 6'd0);
        src[20] = 1'b0; src[26] = 1'b0;
        check_vec("R5 slot 2 alone", 6'd1, 6'd0);
        clear_all();

        // R7: routing of slots 1 and 2 to the high output.
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        wr(4 + 1, (32'(3) << lsb_of(1)) | (32'(5) << lsb_of(2)) | (32'(6) << lsb_of(3)));
        src = '0; src[11] = 1'b1; src[13] = 1'b1; src[14] = 1'b1;
        wr(1, 32'h1 << 6);
        check_vec("R7 slot 1 high", 6'd13, 6'd11);
        wr(1, (32'h1 << 6) | (32'h1 << 4));
        check_vec("R7 slots 1 and 2 high", 6'd14, 6'd11);
        wr(1, (32'h3 << 6) | (32'h2 << 4));
        check_vec("R7 non-one values route low", 6'd11, 6'd0);
        wr(4 + 1, 32'(6) << lsb_of(3));
        wr(1, 32'hFFFF_FFFF);
        check_vec("R7 slot 3 stays low", 6'd14, 6'd0);
        clear_all();

        // R8: promoted source on each output, and when masked.
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        wr(4 + 3, 32'(2) << lsb_of(1));
        src = '0; src[45] = 1'b1; src[26] = 1'b1;
        wr(0, 32'h100 | 32'd45);
        check_vec("R8 promoted on high", 6'd26, 6'd45);
        wr(0, 32'd45);
        check_vec("R8 promoted on low", 6'd45, 6'd0);
        wr(3, 32'hFFFF_DFFF);
        check_vec("R8 promoted but masked", 6'd26, 6'd0);
        clear_all();

        // R9: source 0 never requests, promoted field 0 is none.
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        src = '0; src[0] = 1'b1;
        check_vec("R9 source 0 in every slot", 6'd0, 6'd0);
        wr(0, 32'h100);
        check_vec("R9 promoted field zero", 6'd0, 6'd0);
        clear_all();

        // R10: requests follow inputs with no clock edge.
        wr(2, 32'hFFFF_FFFF);
        wr(4 + 2, 32'(7) << lsb_of(8));
        @(posedge clk); #2;
        src = '0; src[23] = 1'b1;
        #1 chk("R10 same-cycle rise", 32'(irq_low), 32'h1);
        src[23] = 1'b0;
        #1 chk("R10 same-cycle fall", 32'(irq_low), 32'h0);
        clear_all();

        // R5/R7/R8/R10: random settings against the model.
        for (int t = 0; t < 1500; t++) begin
            wr(0, 32'($urandom) & 32'h13F);
            wr(1, 32'($urandom));
            wr(2, 32'($urandom) | 32'($urandom));
            wr(3, 32'($urandom) | 32'($urandom));
            for (int g = 0; g < NG; g++) wr(4 + g, 32'($urandom));
            src = {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)};
            check_model("R5 random arbitration");
            src = NS'(1) << ($urandom % NS);
            check_model("R7 random single source");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule